// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory operand address for a processor whose memory is split into 64 KB segments. For each request it combines a base register, an index register and a displacement into a 16-bit offset. It then picks a 16-bit segment register, shifts it left by four bits and adds the offset to form a 20-bit physical address. A direct form takes the offset straight from the instruction instead.

A string form handles block moves. The source address comes from the data segment and the source index. The destination address comes from the extra segment and the destination index. The form also returns both index values already stepped by the transfer size, upward or downward as the direction input selects.

Requests are accepted one per cycle. Each result appears registered one cycle after its request. The block keeps no architectural state: the register file sends in the current register values and writes back the stepped pointers.

Top module: `seg_addr_gen`

## Requirements
- R1: A request on `req_valid` gives `out_valid` high exactly one cycle later. A cycle without a request gives `out_valid` low one cycle later.
- R2: After reset, `out_valid` is low and every result output reads zero.
- R3: When `mode` is 1 (direct), the offset equals `direct_off`.
- R4: When `mode` is 0 or 3 (memory form), the offset is the sum of three terms. The base term is set by `base_sel`: 1 gives BX, 2 gives BP, and 0 or 3 give zero. The index term is set by `idx_sel`: 1 gives SI, 2 gives DI, and 0 or 3 give zero. The displacement term is set by `disp_sel`.
- R5: When `disp_sel` is 1, the term is `disp[7:0]` sign-extended to 16 bits. When it is 2, the term is all 16 bits of `disp`. When it is 0 or 3, the term is zero.
- R6: All offset sums wrap modulo 2^16.
- R7: `out_pa` equals the selected segment times 16 plus `out_off`, modulo 2^20.
- R8: With no override, a memory form whose base is BP uses SS. Every other memory form, and the direct form, uses DS.
- R9: When `seg_ovr_en` is high in a direct or memory form, `seg_ovr_sel` picks the segment and replaces the default: 0 gives ES, 1 gives CS, 2 gives SS, 3 gives DS.
- R10: When `mode` is 2 (string), `out_off` is SI, `out_pa` is DS:SI and `out_dst_pa` is ES:DI. The segment override inputs have no effect.
- R11: In string form, `out_si` and `out_di` are SI and DI stepped by 1 when `wide` is 0, or by 2 when `wide` is 1. They step upward when `dir` is 0 and downward when `dir` is 1, wrapping modulo 2^16.
- R12: In direct and memory forms, `out_si` and `out_di` return SI and DI unchanged, and `out_dst_pa` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 2 | 0/3 memory form, 1 direct, 2 string |
| base_sel | input | 2 | Base register select |
| idx_sel | input | 2 | Index register select |
| disp_sel | input | 2 | Displacement size select |
| disp | input | 16 | Displacement from the instruction |
| direct_off | input | 16 | Direct offset from the instruction |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_cs | input | 16 | Code segment |
| seg_ds | input | 16 | Data segment |
| seg_ss | input | 16 | Stack segment |
| seg_es | input | 16 | Extra segment |
| seg_ovr_en | input | 1 | Segment override enable |
| seg_ovr_sel | input | 2 | Override segment select |
| wide | input | 1 | String transfer is a word |
| dir | input | 1 | String direction, 1 = downward |
| out_valid | output | 1 | Result valid |
| out_off | output | 16 | Effective offset |
| out_pa | output | 20 | Physical address (source for string form) |
| out_dst_pa | output | 20 | String destination physical address |
| out_si | output | 16 | Next SI |
| out_di | output | 16 | Next DI |

## Verification
The register-based forms are each tried on their own: base only, base plus 8-bit displacement, index plus 16-bit displacement, base plus index, and all three together. A failure therefore shows which adder input or select decode is wrong. A negative 8-bit displacement separates sign extension from zero extension. A sum that passes 0xFFFF, and a segment of 0xFFFF with a small offset, expose missing wrap at each of the two adder widths. Override cases on both a BP form and a BX form show whether the override outranks the default segment. String cases cover all four size and direction pairs, plus pointers at 0 and at 0xFFFF, with the override asserted so that any leak into the string path shows up.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    MODE_MEM    = 2'd0,
    MODE_DIRECT = 2'd1,
    MODE_STRING = 2'd2,
    MODE_MEM_B  = 2'd3
  } sag_mode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } sag_seg_e;
endpackage

// File: rtl/sag_offset.sv
module sag_offset #(
  parameter int AW = 16
) (
  input  logic [1:0]    mode,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    idx_sel,
  input  logic [1:0]    disp_sel,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] direct_off,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  output logic [AW-1:0] off,
  output logic          uses_bp
);
  import sag_pkg::*;
  localparam int DW8 = 8;

  logic [AW-1:0] base_t, idx_t, disp_t;

  always_comb begin
    unique case (base_sel)
      2'd1:    base_t = reg_bx;
      2'd2:    base_t = reg_bp;
      default: base_t = '0;
    endcase
    unique case (idx_sel)
      2'd1:    idx_t = reg_si;
      2'd2:    idx_t = reg_di;
      default: idx_t = '0;
    endcase
    unique case (disp_sel)
      2'd1:    disp_t = {{(AW-DW8){disp[DW8-1]}}, disp[DW8-1:0]};
      2'd2:    disp_t = disp;
      default: disp_t = '0;
    endcase
  end

  always_comb begin
    uses_bp = 1'b0;
    unique case (sag_mode_e'(mode))
      MODE_DIRECT: off = direct_off;
      MODE_STRING: off = reg_si;
      default: begin
        off     = base_t + idx_t + disp_t;
        uses_bp = (base_sel == 2'd2);
      end
    endcase
  end
endmodule

// File: rtl/sag_phys.sv
module sag_phys #(
  parameter int AW    = 16,
  parameter int SHIFT = 4
) (
  input  logic [1:0]          seg_id,
  input  logic [AW-1:0]       seg_cs,
  input  logic [AW-1:0]       seg_ds,
  input  logic [AW-1:0]       seg_ss,
  input  logic [AW-1:0]       seg_es,
  input  logic [AW-1:0]       off,
  output logic [AW+SHIFT-1:0] pa
);
  import sag_pkg::*;
  localparam int PAW = AW + SHIFT;

  logic [AW-1:0] seg_v;

  always_comb begin
    unique case (sag_seg_e'(seg_id))
      SEG_ES:  seg_v = seg_es;
      SEG_CS:  seg_v = seg_cs;
      SEG_SS:  seg_v = seg_ss;
      default: seg_v = seg_ds;
    endcase
  end

  assign pa = {seg_v, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};

  // PAW is the width of the result; it is named here only for readers.
  logic [PAW-1:0] unused_width_marker;
  assign unused_width_marker = pa;
endmodule

// File: rtl/sag_strptr.sv
module sag_strptr #(
  parameter int AW = 16
) (
  input  logic          wide,
  input  logic          dir,
  input  logic [AW-1:0] ptr_in,
  output logic [AW-1:0] ptr_out
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] step;

  always_comb begin
    step    = wide ? STEP_W : STEP_B;
    ptr_out = dir ? (ptr_in - step) : (ptr_in + step);
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW    = 16,
  parameter int SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          mode,
  input  logic [1:0]          base_sel,
  input  logic [1:0]          idx_sel,
  input  logic [1:0]          disp_sel,
  input  logic [AW-1:0]       disp,
  input  logic [AW-1:0]       direct_off,
  input  logic [AW-1:0]       reg_bx,
  input  logic [AW-1:0]       reg_bp,
  input  logic [AW-1:0]       reg_si,
  input  logic [AW-1:0]       reg_di,
  input  logic [AW-1:0]       seg_cs,
  input  logic [AW-1:0]       seg_ds,
  input  logic [AW-1:0]       seg_ss,
  input  logic [AW-1:0]       seg_es,
  input  logic                seg_ovr_en,
  input  logic [1:0]          seg_ovr_sel,
  input  logic                wide,
  input  logic                dir,
  output logic                out_valid,
  output logic [AW-1:0]       out_off,
  output logic [AW+SHIFT-1:0] out_pa,
  output logic [AW+SHIFT-1:0] out_dst_pa,
  output logic [AW-1:0]       out_si,
  output logic [AW-1:0]       out_di
);
  import sag_pkg::*;
  localparam int PAW = AW + SHIFT;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic            is_str;
  logic [AW-1:0]   off_c;
  logic            uses_bp;
  logic [1:0]      src_seg, dst_seg;
  logic [PAW-1:0]  src_pa_c, dst_pa_c;
  logic [AW-1:0]   si_step, di_step;

  assign is_str = (sag_mode_e'(mode) == MODE_STRING);

  sag_offset #(.AW(AW)) off_i (
    .mode(mode), .base_sel(base_sel), .idx_sel(idx_sel), .disp_sel(disp_sel),
    .disp(disp), .direct_off(direct_off), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .off(off_c), .uses_bp(uses_bp)
  );

  always_comb begin
    dst_seg = SEG_ES;
    if (is_str)          src_seg = SEG_DS;
    else if (seg_ovr_en) src_seg = seg_ovr_sel;
    else if (uses_bp)    src_seg = SEG_SS;
    else                 src_seg = SEG_DS;
  end

  sag_phys #(.AW(AW), .SHIFT(SHIFT)) src_pa_i (
    .seg_id(src_seg), .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss),
    .seg_es(seg_es), .off(off_c), .pa(src_pa_c)
  );

  sag_phys #(.AW(AW), .SHIFT(SHIFT)) dst_pa_i (
    .seg_id(dst_seg), .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss),
    .seg_es(seg_es), .off(reg_di), .pa(dst_pa_c)
  );

  sag_strptr #(.AW(AW)) si_step_i (
    .wide(wide), .dir(dir), .ptr_in(reg_si), .ptr_out(si_step)
  );
  sag_strptr #(.AW(AW)) di_step_i (
    .wide(wide), .dir(dir), .ptr_in(reg_di), .ptr_out(di_step)
  );

  // next-state
  logic [AW-1:0]  off_d, si_d, di_d;
  logic [PAW-1:0] pa_d, dst_d;

  always_comb begin
    off_d = off_c;
    pa_d  = src_pa_c;
    if (is_str) begin
      dst_d = dst_pa_c;
      si_d  = si_step;
      di_d  = di_step;
    end else begin
      dst_d = '0;
      si_d  = reg_si;
      di_d  = reg_di;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_off    <= '0;
      out_pa     <= '0;
      out_dst_pa <= '0;
      out_si     <= '0;
      out_di     <= '0;
    end else if (req_valid) begin
      out_off    <= off_d;
      out_pa     <= pa_d;
      out_dst_pa <= dst_d;
      out_si     <= si_d;
      out_di     <= di_d;
    end
  end
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int AW    = 16,
  parameter int SHIFT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          mode,
  input logic [AW-1:0]       direct_off,
  input logic [AW-1:0]       reg_si,
  input logic [AW-1:0]       reg_di,
  input logic [AW-1:0]       seg_ds,
  input logic                seg_ovr_en,
  input logic                wide,
  input logic                dir,
  input logic                out_valid,
  input logic [AW-1:0]       out_off,
  input logic [AW+SHIFT-1:0] out_pa,
  input logic [AW+SHIFT-1:0] out_dst_pa,
  input logic [AW-1:0]       out_si,
  input logic [AW-1:0]       out_di
);
  localparam int PAW = AW + SHIFT;

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  a_r3_direct_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'd1) |=> (out_off == $past(direct_off)));

  a_r7_direct_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'd1 && !seg_ovr_en) |=>
      (out_pa == PAW'({$past(seg_ds), {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, out_off})));

  a_r11_byte_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'd2 && !wide && !dir) |=>
      (out_si == $past(reg_si) + AW'(1) && out_di == $past(reg_di) + AW'(1)));

  a_r12_pointers_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode != 2'd2) |=>
      (out_si == $past(reg_si) && out_di == $past(reg_di) && out_dst_pa == '0));
endmodule

bind seg_addr_gen sag_checker #(.AW(AW), .SHIFT(SHIFT)) chk_i (.*);

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        req_valid;
  logic [1:0]  mode, base_sel, idx_sel, disp_sel, seg_ovr_sel;
  logic [15:0] disp, direct_off, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_cs, seg_ds, seg_ss, seg_es;
  logic        seg_ovr_en, wide, dir;
  logic        out_valid;
  logic [15:0] out_off, out_si, out_di;
  logic [19:0] out_pa, out_dst_pa;

  seg_addr_gen dut_i (.*);

  typedef struct {
    logic [15:0] off;
    logic [19:0] pa;
    logic [19:0] dst;
    logic [15:0] si;
    logic [15:0] di;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [15:0] b, x, d, sv, st;
    logic [1:0]  sid;
    e.tag = tag;
    if (mode == 2'd2) begin
      st    = wide ? 16'd2 : 16'd1;
      e.off = reg_si;
      e.pa  = phys(seg_ds, reg_si);
      e.dst = phys(seg_es, reg_di);
      e.si  = dir ? reg_si - st : reg_si + st;
      e.di  = dir ? reg_di - st : reg_di + st;
    end else begin
      sid = 2'd3;
      if (mode == 2'd1) e.off = direct_off;
      else begin
        b = (base_sel == 2'd1) ? reg_bx : (base_sel == 2'd2) ? reg_bp : 16'd0;
        x = (idx_sel == 2'd1) ? reg_si : (idx_sel == 2'd2) ? reg_di : 16'd0;
        d = (disp_sel == 2'd1) ? {{8{disp[7]}}, disp[7:0]} :
            (disp_sel == 2'd2) ? disp : 16'd0;
        e.off = b + x + d;
        if (base_sel == 2'd2) sid = 2'd2;
      end
      if (seg_ovr_en) sid = seg_ovr_sel;
      sv = (sid == 2'd0) ? seg_es : (sid == 2'd1) ? seg_cs :
           (sid == 2'd2) ? seg_ss : seg_ds;
      e.pa  = phys(sv, e.off);
      e.dst = 20'd0;
      e.si  = reg_si;
      e.di  = reg_di;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string f, input logic [19:0] act,
                     input logic [19:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
    end
  endtask

  // driver: called right after a falling edge, once inputs are set
  task automatic go(input string tag);
    req_valid = 1'b1;
    q.push_back(model(tag));
  endtask

  task automatic prep;
    @(negedge clk);
    mode = 2'd0; base_sel = 2'd0; idx_sel = 2'd0; disp_sel = 2'd0;
    disp = 16'd0; seg_ovr_en = 1'b0; seg_ovr_sel = 2'd0; wide = 1'b0; dir = 1'b0;
    reg_si = 16'h0300; reg_di = 16'h0040; seg_ds = 16'h1234;
  endtask

  // monitor
  bit mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      exp_t e;
      if (q.size() == 0) chk("R1", "unexpected valid", 20'd1, 20'd0);
      else begin
        e = q.pop_front();
        chk(e.tag, "off", {4'h0, out_off}, {4'h0, e.off});
        chk(e.tag, "pa", out_pa, e.pa);
        chk(e.tag, "dst_pa", out_dst_pa, e.dst);
        chk(e.tag, "si", {4'h0, out_si}, {4'h0, e.si});
        chk(e.tag, "di", {4'h0, out_di}, {4'h0, e.di});
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    mode = 2'd0; base_sel = 2'd0; idx_sel = 2'd0; disp_sel = 2'd0;
    disp = 16'd0; direct_off = 16'd0; seg_ovr_en = 1'b0; seg_ovr_sel = 2'd0;
    wide = 1'b0; dir = 1'b0;
    reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0300; reg_di = 16'h0040;
    seg_cs = 16'h4000; seg_ds = 16'h1234; seg_ss = 16'h3000; seg_es = 16'h5000;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2", "valid", {19'd0, out_valid}, 20'd0);
    chk("R2", "pa", out_pa | out_dst_pa, 20'd0);
    chk("R2", "regs", {4'h0, out_off | out_si | out_di}, 20'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    prep; mode = 2'd1; direct_off = 16'h5678; go("R3 R7 direct");
    prep; base_sel = 2'd1; go("R4 R8 BX");
    prep; base_sel = 2'd2; disp_sel = 2'd1; disp = 16'h12F0; go("R5 R8 BP+d8neg");
    prep; idx_sel = 2'd1; disp_sel = 2'd2; disp = 16'h0123; go("R4 R5 SI+d16");
    prep; base_sel = 2'd1; idx_sel = 2'd1; go("R4 BX+SI");
    prep; base_sel = 2'd2; idx_sel = 2'd2; disp_sel = 2'd2; disp = 16'hFF00;
      go("R6 R8 BP+DI+d16 wrap");
    prep; base_sel = 2'd1; idx_sel = 2'd2; disp_sel = 2'd1; disp = 16'h007F;
      seg_ovr_en = 1'b1; seg_ovr_sel = 2'd0; go("R9 ES override");
    prep; base_sel = 2'd2; seg_ovr_en = 1'b1; seg_ovr_sel = 2'd1; go("R9 CS over BP");
    prep; mode = 2'd3; base_sel = 2'd3; idx_sel = 2'd3; disp_sel = 2'd3;
      disp = 16'hFFFF; go("R4 R5 unused selects");
    prep; mode = 2'd1; direct_off = 16'h0010; seg_ds = 16'hFFFF; go("R7 pa wrap");
    prep; mode = 2'd2; seg_ovr_en = 1'b1; seg_ovr_sel = 2'd1; go("R10 R11 byte up");
    prep; mode = 2'd2; wide = 1'b1; dir = 1'b1; go("R11 word down");
    prep; mode = 2'd2; wide = 1'b1; dir = 1'b1; reg_si = 16'h0000; reg_di = 16'h0001;
      go("R11 word down wrap");
    prep; mode = 2'd2; wide = 1'b1; reg_si = 16'hFFFF; reg_di = 16'hFFFE;
      go("R11 word up wrap");
    prep; mode = 2'd2; dir = 1'b1; seg_ovr_en = 1'b1; seg_ovr_sel = 2'd2;
      go("R10 R11 byte down");

    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "idle valid", {19'd0, out_valid}, 20'd0);
    chk("R1", "queue left", 20'(q.size()), 20'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule